// File: doc/BRIEF.md
# Multi-Segment Receive Stream Serializer

This block takes a receive bus that is four segments wide and turns it into a stream one segment wide. Each input segment carries a data word and three flags: start of packet, end of packet and data-valid. In one cycle a packet may start in any segment, several packets may start or end, and a packet may carry on from the highest segment into segment 0 of the next cycle. The upstream side cannot be stalled, so the block stores every valid segment in a small internal queue, in segment-index order. The queue sends out one entry per cycle over a valid/ready handshake, and each entry keeps its start and end markers.

Segments whose data-valid is low are skipped, including when they fall in the middle of an open packet. Whatever flags such a segment carries are ignored. A rule checker follows packet framing across segments and across cycles. It raises sticky flags for two kinds of fault: bus-rule violations, which are too many starts in a cycle or the upper segments used while the lower two are idle, and framing faults. A third sticky flag marks queue overflow. The block only reports these faults and keeps running as before.

Top module: `rxser_top`

## Requirements
- R1: After reset, `out_valid` is 0 and the flags `err_proto`, `err_frame` and `err_overflow` are all 0.
- R2: Valid input segments come out in ascending segment order within a cycle (segment i sits at `in_data[i*32 +: 32]`, and its flags at bit i of each flag vector). Earlier cycles come out before later ones. Each output entry carries the data, start and end flags of its input segment unchanged.
- R3: A segment with `in_dvalid` low is never emitted. Its `in_sop` and `in_eop` bits have no effect on framing or on error flags.
- R4: The head entry leaves only on a cycle where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold steady.
- R5: If all four segments carry start and data-valid in the same cycle, `err_proto` is set from the next cycle onward. Three starts in a cycle do not set it.
- R6: If segment 2 or segment 3 is data-valid while segments 0 and 1 are both not valid, `err_proto` is set from the next cycle onward.
- R7: Framing is tracked per valid segment, in index order, and carries across cycles. A start while a packet is open, or an end with no packet open, sets `err_frame` from the next cycle onward. A start opens a new packet. A segment with both start and end is a complete packet.
- R8: The queue holds 16 entries. The free space is counted before that cycle's output transfer. Valid segments that do not fit are dropped, highest index first, and `err_overflow` is set. The entries that were accepted come out intact.
- R9: A segment written while the queue is empty shows up on the outputs in the next cycle.
- R10: Synchronous active-high `rst` empties the queue, closes any open packet and clears all three error flags. The three flags are sticky and only `rst` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 128 | Four segment data words, segment i at bits [i*32 +: 32] |
| in_sop | input | 4 | Start-of-packet per segment |
| in_eop | input | 4 | End-of-packet per segment |
| in_dvalid | input | 4 | Data-valid per segment |
| out_valid | output | 1 | Output entry available |
| out_ready | input | 1 | Downstream accepts the output entry |
| out_data | output | 32 | Output data word |
| out_sop | output | 1 | Output entry starts a packet |
| out_eop | output | 1 | Output entry ends a packet |
| err_proto | output | 1 | Sticky bus-rule violation flag |
| err_frame | output | 1 | Sticky framing fault flag |
| err_overflow | output | 1 | Sticky queue overflow flag |

## Verification
The hardest case to reach is a write that only partly fits: some segments of one cycle are accepted and the higher-indexed ones are dropped. The stimulus gets there by holding `out_ready` low and filling the queue to exactly 14 entries with whole cycles of single-segment packets. It then drives a full four-segment cycle. This shows that segments 0 and 1 land and 2 and 3 are lost. A full drain then confirms the order of all sixteen stored words. Framing that carries across cycles is reached by opening a packet in segment 3 and closing it in segment 0 of a later cycle. A packet is left open across a reset, and an end-only segment afterwards shows that the reset closed it.

// File: rtl/rxser_pkg.sv
package rxser_pkg;
    localparam int NSEG    = 4;
    localparam int DATA_W  = 32;
    localparam int MAX_SOP = 3;
    localparam int PW      = $clog2(NSEG + 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
    } seg_t;

    function automatic logic too_many_starts(input logic [NSEG-1:0] starts);
        return $countones(starts) > MAX_SOP;
    endfunction

    function automatic logic upper_without_lower(input logic [NSEG-1:0] dv);
        return (dv[1:0] == 2'b00) && (dv[NSEG-1:2] != '0);
    endfunction
endpackage

// File: rtl/rxser_rules.sv
module rxser_rules
    import rxser_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSEG-1:0] dv,
    input  logic [NSEG-1:0] sop,
    input  logic [NSEG-1:0] eop,
    output logic            err_proto,
    output logic            err_frame
);
    logic open_q, open_d, frame_bad, proto_bad;

    always_comb begin
        open_d    = open_q;
        frame_bad = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            if (dv[i]) begin
                if (sop[i]) begin
                    if (open_d) frame_bad = 1'b1;
                    open_d = !eop[i];
                end else if (eop[i]) begin
                    if (!open_d) frame_bad = 1'b1;
                    open_d = 1'b0;
                end
            end
        end
        proto_bad = too_many_starts(sop & dv) || upper_without_lower(dv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            err_proto <= 1'b0;
            err_frame <= 1'b0;
        end else begin
            open_q    <= open_d;
            err_proto <= err_proto | proto_bad;
            err_frame <= err_frame | frame_bad;
        end
    end
endmodule

// File: rtl/rxser_pack.sv
module rxser_pack
    import rxser_pkg::*;
(
    input  logic [NSEG-1:0] dv,
    output logic [PW-1:0]   pos [NSEG]
);
    assign pos[0] = '0;
    for (genvar i = 1; i < NSEG; i++) begin : g_prefix
        assign pos[i] = pos[i-1] + PW'(dv[i-1]);
    end
endmodule

// File: rtl/rxser_fifo.sv
module rxser_fifo
    import rxser_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  seg_t            wseg [NSEG],
    input  logic [NSEG-1:0] dv,
    input  logic [PW-1:0]   pos  [NSEG],
    input  logic            pop,
    output seg_t            head,
    output logic            nonempty,
    output logic            ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    seg_t            mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count, free, n_acc;
    logic [NSEG-1:0] acc;
    logic [AW-1:0]   widx [NSEG];

    always_comb begin
        free  = CW'(DEPTH) - count;
        n_acc = '0;
        for (int i = 0; i < NSEG; i++) begin
            acc[i]  = dv[i] && (CW'(pos[i]) < free);
            widx[i] = wr_ptr + AW'(pos[i]);
            n_acc   = n_acc + CW'(acc[i]);
        end
        ovf = |(dv & ~acc);
    end

    assign nonempty = (count != '0);
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSEG; i++) begin
            if (acc[i]) mem[widx[i]] <= wseg[i];
        end
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(n_acc);
            rd_ptr <= rd_ptr + AW'(pop);
            count  <= count + n_acc - CW'(pop);
        end
    end
endmodule

// File: rtl/rxser_top.sv
module rxser_top
    import rxser_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSEG*DATA_W-1:0] in_data,
    input  logic [NSEG-1:0]        in_sop,
    input  logic [NSEG-1:0]        in_eop,
    input  logic [NSEG-1:0]        in_dvalid,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DATA_W-1:0]      out_data,
    output logic                   out_sop,
    output logic                   out_eop,
    output logic                   err_proto,
    output logic                   err_frame,
    output logic                   err_overflow
);
    seg_t          wseg [NSEG];
    logic [PW-1:0] pos  [NSEG];
    seg_t          head;
    logic          ovf;

    for (genvar i = 0; i < NSEG; i++) begin : g_unpack
        assign wseg[i] = '{data: in_data[i*DATA_W +: DATA_W], sop: in_sop[i], eop: in_eop[i]};
    end

    rxser_rules u_rules (
        .clk(clk), .rst(rst), .dv(in_dvalid), .sop(in_sop), .eop(in_eop),
        .err_proto(err_proto), .err_frame(err_frame)
    );

    rxser_pack u_pack (.dv(in_dvalid), .pos(pos));

    rxser_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .wseg(wseg), .dv(in_dvalid), .pos(pos),
        .pop(out_valid && out_ready), .head(head), .nonempty(out_valid), .ovf(ovf)
    );

    assign out_data = head.data;
    assign out_sop  = head.sop;
    assign out_eop  = head.eop;

    always_ff @(posedge clk) begin
        if (rst) err_overflow <= 1'b0;
        else     err_overflow <= err_overflow | ovf;
    end
endmodule

// File: rtl/rxser_sva.sv
module rxser_sva
    import rxser_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSEG-1:0]   in_sop,
    input logic [NSEG-1:0]   in_dvalid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              err_proto,
    input logic              err_frame,
    input logic              err_overflow
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    assert_four_starts_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(in_sop & in_dvalid) == NSEG) |=> err_proto);

    assert_upper_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (in_dvalid[1:0] == 2'b00 && in_dvalid[NSEG-1:2] != '0) |=> err_proto);

    assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && in_dvalid != '0) |=> out_valid);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (err_proto || err_frame || err_overflow) |=>
        ((err_proto >= $past(err_proto)) && (err_frame >= $past(err_frame)) && (err_overflow >= $past(err_overflow))));

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !err_proto && !err_frame && !err_overflow));
endmodule

bind rxser_top rxser_sva u_sva (.*);

// File: tb/rxser_top_tb_top.sv
module rxser_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] in_data;
    logic [3:0]   in_sop, in_eop, in_dvalid;
    logic         out_valid, out_ready, out_sop, out_eop;
    logic [31:0]  out_data;
    logic         err_proto, err_frame, err_overflow;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [31:0] q_data [$];
    logic        q_sop  [$];
    logic        q_eop  [$];
    int next_word = 32'h100;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxser_top dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .in_dvalid(in_dvalid), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .err_proto(err_proto), .err_frame(err_frame), .err_overflow(err_overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_dvalid = '0; in_sop = '0; in_eop = '0; out_ready = 0;
        @(negedge clk);
        rst = 0;
        q_data.delete(); q_sop.delete(); q_eop.delete();
    endtask

    // One input cycle; the first lim valid segments are expected to be stored.
    task automatic drive(input logic [3:0] dv, input logic [3:0] s, input logic [3:0] e, input int lim);
        int taken = 0;
        @(negedge clk);
        in_dvalid = dv; in_sop = s; in_eop = e;
        for (int i = 0; i < 4; i++) begin
            in_data[i*32 +: 32] = next_word;
            if (dv[i] && taken < lim) begin
                q_data.push_back(next_word); q_sop.push_back(s[i]); q_eop.push_back(e[i]);
                taken++;
            end
            next_word++;
        end
        @(negedge clk);
        in_dvalid = '0; in_sop = '0; in_eop = '0;
    endtask

    task automatic drain(input string req);
        out_ready = 1;
        while (q_data.size() > 0) begin
            logic [31:0] d = q_data.pop_front();
            logic sp = q_sop.pop_front();
            logic ep = q_eop.pop_front();
            chk(out_valid, req, 32'(out_valid), 1);
            chk(out_data == d && out_sop == sp && out_eop == ep, req, out_data, d);
            @(negedge clk);
        end
        out_ready = 0;
        chk(!out_valid, req, 32'(out_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(!out_valid, "R1", 32'(out_valid), 0);
        chk({err_proto, err_frame, err_overflow} == 3'b000, "R1", 32'({err_proto, err_frame, err_overflow}), 0);
    endtask

    task automatic t_order_hold();
        logic [31:0] d0;
        do_reset();
        drive(4'b1111, 4'b0101, 4'b0010, 4);   // seg0 sop, seg1 eop, seg2 sop, seg3 mid
        drive(4'b0011, 4'b0000, 4'b0010, 4);   // continues, ends in seg1
        d0 = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == d0, "R4", out_data, d0);
        chk(!err_frame && !err_proto, "R2", 32'({err_frame, err_proto}), 0);
        drain("R2");
    endtask

    task automatic t_gaps();
        do_reset();
        drive(4'b1011, 4'b0101, 4'b1000, 4);   // seg2 invalid carrying a stray sop
        chk(!err_frame, "R3", 32'(err_frame), 0);
        drain("R3");
    endtask

    task automatic t_latency_cross();
        do_reset();
        out_ready = 1;
        drive(4'b1001, 4'b1001, 4'b0001, 4);   // seg0 whole packet, seg3 opens
        chk(out_valid, "R9", 32'(out_valid), 1);
        drive(4'b0001, 4'b0000, 4'b0001, 4);   // closes in seg0 of a later cycle
        chk(!err_frame, "R7", 32'(err_frame), 0);
        @(negedge clk);
        out_ready = 0;
        q_data.delete(); q_sop.delete(); q_eop.delete();
        chk(!out_valid, "R4", 32'(out_valid), 0);
    endtask

    task automatic t_starts();
        do_reset();
        drive(4'b1111, 4'b0111, 4'b1011, 4);   // three starts
        chk(!err_proto && !err_frame, "R5", 32'({err_proto, err_frame}), 0);
        drive(4'b1111, 4'b1111, 4'b1111, 4);   // four starts
        chk(err_proto, "R5", 32'(err_proto), 1);
        repeat (2) @(negedge clk);
        chk(err_proto, "R10", 32'(err_proto), 1);
    endtask

    task automatic t_gap_rule();
        do_reset();
        drive(4'b0001, 4'b0001, 4'b0001, 4);
        chk(!err_proto, "R6", 32'(err_proto), 0);
        drive(4'b0100, 4'b0100, 4'b0100, 4);
        chk(err_proto, "R6", 32'(err_proto), 1);
    endtask

    task automatic t_framing();
        do_reset();
        drive(4'b0001, 4'b0000, 4'b0001, 4);   // end with nothing open
        chk(err_frame, "R7", 32'(err_frame), 1);
        do_reset();
        drive(4'b0011, 4'b0011, 4'b0000, 4);   // start while open; seg1 left open
        chk(err_frame, "R7", 32'(err_frame), 1);
        do_reset();
        chk(!err_frame && !out_valid, "R10", 32'({err_frame, out_valid}), 0);
        drive(4'b0001, 4'b0000, 4'b0001, 4);   // open packet was closed by reset
        chk(err_frame, "R10", 32'(err_frame), 1);
    endtask

    task automatic t_overflow();
        do_reset();
        repeat (3) drive(4'b1111, 4'b1111, 4'b1111, 4);
        drive(4'b0011, 4'b0011, 4'b0011, 4);
        chk(!err_overflow, "R8", 32'(err_overflow), 0);
        drive(4'b1111, 4'b1111, 4'b1111, 2);   // only two fit
        chk(err_overflow, "R8", 32'(err_overflow), 1);
        chk(q_data.size() == 16, "R8", 32'(q_data.size()), 16);
        drain("R8");
    endtask

    initial begin
        rst = 1; out_ready = 0; in_data = '0;
        in_dvalid = '0; in_sop = '0; in_eop = '0;
        t_reset();
        t_order_hold();
        t_gaps();
        t_latency_cross();
        t_starts();
        t_gap_rule();
        t_framing();
        t_overflow();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule